// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one active-low external interrupt pin and holds a pending request for the CPU. The pin first passes through a reset-initialised synchronizer. The synchronized level then feeds an edge detector and a request latch, and it also goes out on its own port so software can test the pin directly.

A single byte-wide control/status register sits at a parameterised address, 0x1D by default. It holds a mode bit, a local mask bit, a write-only acknowledge bit and a read-only pending flag. With the mode bit clear, only falling edges set the latch. With the mode bit set, a low level also sets it, so the latch cannot clear until an acknowledge arrives while the pin is high.

The request to the CPU is the latch gated by the local mask and by a global-mask input that mirrors the CPU's interrupt-disable state. Either a vector-fetch strobe from the CPU or a software write clears the latch.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00, irq_req is 0, and pin_level is 1 when the pin is held high.
- R2: pin_level equals the pin value from SYNC_STAGES (2) clock edges earlier.
- R3: In edge mode (bit 0 = 0), a falling edge sets the flag (bit 3) on the third clock edge after the pin changes. A pin held low afterwards produces no further set, so the flag stays 0 once acknowledged.
- R4: In level mode (bit 0 = 1), a low synchronized pin sets the flag, and an acknowledge while the pin is low leaves it set. The flag clears only on an acknowledge given after the synchronized pin has returned high.
- R5: An acknowledge clears the flag on the next clock edge. An acknowledge is a one-cycle vec_fetch pulse or a register write with bit 2 = 1. In edge mode this works whatever the pin level.
- R6: With the local mask (bit 1) set, irq_req stays 0, but the latch still sets and bit 3 still shows it.
- R7: With cpu_gmask high, irq_req stays 0. Otherwise irq_req = flag AND NOT mask.
- R8: Bits 7..4 and bit 2 always read 0. Writing bit 3 has no effect on the flag.
- R9: Reads at any other address return 0, and writes there leave the register unchanged.
- R10: When a set event and an acknowledge fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| vec_fetch | input | 1 | CPU vector-fetch strobe, acknowledges the request |
| cpu_gmask | input | 1 | Global interrupt mask from the CPU |
| irq_req | output | 1 | Interrupt request to the CPU |
| pin_level | output | 1 | Synchronized pin level |

## Verification
The assertions assume that vec_fetch and bus_wr are one-cycle strobes. They also assume the pin only changes at clock-independent points and is held for longer than the synchronizer depth, so a low level seen by the latch comes from a real pin state. The stimulus drives every input on the falling clock edge and holds each pin level for at least three cycles. It issues acknowledges only as isolated single-cycle pulses, which keeps all traffic inside those assumptions while sweeping every mode, local-mask and global-mask combination.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h1D,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_pin_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              vec_fetch,
  input  logic              cpu_gmask,
  output logic              irq_req,
  output logic              pin_level
);
  localparam int FLAG_BIT = 3;
  localparam int ACK_BIT  = 2;
  localparam int MASK_BIT = 1;
  localparam int MODE_BIT = 0;

  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_s, prev_q, flag_q, mask_q, mode_q;
  logic csr_hit, wr_hit, ack, fall, set_ev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], irq_pin_n};

  assign pin_s     = sync_q[SYNC_STAGES-1];
  assign pin_level = pin_s;

  assign csr_hit = (bus_addr == CSR_ADDR);
  assign wr_hit  = bus_wr & csr_hit;
  assign ack     = vec_fetch | (wr_hit & bus_wdata[ACK_BIT]);
  assign fall    = prev_q & ~pin_s;
  assign set_ev  = fall | (mode_q & ~pin_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
      mask_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (set_ev)   flag_q <= 1'b1;
      else if (ack) flag_q <= 1'b0;
      if (wr_hit) begin
        mask_q <= bus_wdata[MASK_BIT];
        mode_q <= bus_wdata[MODE_BIT];
      end
    end

  always_comb begin
    bus_rdata = '0;
    if (csr_hit) begin
      bus_rdata[FLAG_BIT] = flag_q;
      bus_rdata[MASK_BIT] = mask_q;
      bus_rdata[MODE_BIT] = mode_q;
    end
  end

  assign irq_req = flag_q & ~mask_q & ~cpu_gmask;
endmodule

module ext_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_s,
  input logic       prev_q,
  input logic       flag_q,
  input logic       mask_q,
  input logic       mode_q,
  input logic       ack,
  input logic       cpu_gmask,
  input logic       irq_req,
  input logic [7:0] bus_rdata
);
  AST_GMASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) cpu_gmask |-> !irq_req); // R7
  AST_LMASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) mask_q |-> !irq_req); // R6
  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n) (mode_q && !pin_s) |=> flag_q); // R4
  AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ack && !mode_q && !(prev_q && !pin_s)) |=> !flag_q); // R5
  AST_FLAG_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag_q) |-> $past(!pin_s)); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_rdata[7:4] == 4'h0) && !bus_rdata[2]); // R8
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .prev_q(prev_q), .flag_q(flag_q),
  .mask_q(mask_q), .mode_q(mode_q), .ack(ack), .cpu_gmask(cpu_gmask),
  .irq_req(irq_req), .bus_rdata(bus_rdata)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam logic [7:0] CSR = 8'h1D;
  logic clk = 0, rst_n = 0, irq_pin_n = 1, bus_wr = 0, vec_fetch = 0, cpu_gmask = 0;
  logic [7:0] bus_addr = CSR, bus_wdata = 0, bus_rdata;
  logic irq_req, pin_level;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vec_fetch(vec_fetch), .cpu_gmask(cpu_gmask), .irq_req(irq_req), .pin_level(pin_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    tick(1);
    bus_wr = 0; bus_addr = CSR;
  endtask

  task automatic vf();
    vec_fetch = 1;
    tick(1);
    vec_fetch = 0;
  endtask

  function automatic int regv(input int f, input int m, input int md);
    return f * 8 + m * 2 + md;
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    chk("R1 reg", bus_rdata, 0);
    chk("R1 irq", irq_req, 0);
    chk("R1 pin", pin_level, 1);

    wr(CSR, 8'hFC);
    chk("R8 rsvd/ro", bus_rdata, 0);

    wr(8'h1C, 8'h03);
    chk("R9 write elsewhere", bus_rdata, 0);
    bus_addr = 8'h1C; #1;
    chk("R9 read elsewhere", bus_rdata, 0);
    bus_addr = CSR;

    for (int md = 0; md < 2; md++)
      for (int lm = 0; lm < 2; lm++)
        for (int gm = 0; gm < 2; gm++) begin
          cpu_gmask = gm[0];
          wr(CSR, 8'(lm * 2 + md));
          chk("R8 cfg read", bus_rdata, regv(0, lm, md));
          irq_pin_n = 0;
          tick(1);
          chk("R2 not yet", pin_level, 1);
          tick(1);
          chk("R2 synced low", pin_level, 0);
          chk("R3 flag not yet", bus_rdata[3], 0);
          tick(1);
          chk("R3 R4 flag set", bus_rdata, regv(1, lm, md));
          chk("R6 R7 irq", irq_req, int'(lm == 0 && gm == 0));
          if (gm == 0) vf(); else wr(CSR, 8'(4 + lm * 2 + md));
          chk("R4 R5 ack while low", bus_rdata[3], md);
          tick(4);
          chk("R3 single edge", bus_rdata[3], md);
          irq_pin_n = 1;
          tick(3);
          chk("R2 synced high", pin_level, 1);
          chk("R4 held after high", bus_rdata[3], md);
          if (gm == 0) wr(CSR, 8'(4 + lm * 2 + md)); else vf();
          chk("R4 R5 cleared", bus_rdata, regv(0, lm, md));
          chk("R7 irq off", irq_req, 0);
        end

    cpu_gmask = 0;
    for (int md = 0; md < 2; md++) begin
      wr(CSR, 8'(md));
      irq_pin_n = 0;
      tick(2);
      vf();
      chk("R10 set beats ack", bus_rdata[3], 1);
      chk("R7 irq follows flag", irq_req, 1);
      irq_pin_n = 1;
      tick(3);
      vf();
      chk("R5 clear after", bus_rdata[3], 0);
    end
    summary();
  end
endmodule